// File: doc/BRIEF.md
# Serial Flash Status Protection Unit

This block owns the 16-bit status/control word of a serial NOR flash and decides, for each decoded command strobe, whether that command may run. It sees the write-enable, write-disable, status-write, page-program, sector-erase, block-erase and chip-erase strobes. It also sees a precomputed flag that says whether the addressed region is block-protected, the active-low write-protect pin and a power-cycle pulse. In the cycle a strobe is present it raises exactly one of `cmd_accept` or `cmd_reject`. An accepted status write, program or erase starts a modelled internal operation that keeps the busy flag high for `OP_CYCLES` clock cycles.

The control lies in a two-state machine. In `ST_IDLE` an accepted status write, program or erase takes the transition IDLE→BUSY and starts the operation timer. In `ST_BUSY` the transition BUSY→IDLE happens when the timer reaches its last cycle. On that transition a pending status-write value is committed and the write-enable latch is cleared. A power-cycle pulse forces BUSY→IDLE from any state and abandons the operation. A write-enable or write-disable is accepted in IDLE without leaving it.

The status-register protection field (bits 8:7) chooses how status writes are gated. Value 00 is free. Value 01 depends on the pin. Value 10 is locked until the next power cycle, which clears the field to 00. Value 11 is locked for good.

Top module: `flash_status_guard`

## Requirements
- R1: After reset `status_q` is 16'h0000, `busy` is 0 and no command is in progress.
- R2: In IDLE, a write-enable strobe is accepted and sets bit 1 (write-enable latch) of `status_q` in the next cycle. A write-disable strobe is accepted and clears that bit.
- R3: When bit 1 is 0, status-write, program, sector-erase, block-erase and chip-erase strobes are rejected.
- R4: With bits 8:7 = 00 a status write is allowed at either level of `wp_n`. With bits 8:7 = 01 it is rejected while `wp_n` is 0 and allowed while `wp_n` is 1.
- R5: With bits 8:7 = 10 every status write is rejected. A `pwr_cycle` pulse sets bits 8:7 to 00 and clears bit 1, and it ends any running operation in the next cycle.
- R6: With bits 8:7 = 11 every status write is rejected, and `pwr_cycle` leaves bits 8:7 at 11.
- R7: Program, sector-erase and block-erase strobes are rejected when `region_protected` is 1.
- R8: A chip erase is accepted only when bits 4:2 are all 0 and bit 14 is 0.
- R9: An accepted status write, program or erase drives bit 0 of `status_q` and `busy` high for exactly `OP_CYCLES` cycles, starting in the cycle after acceptance. `busy` always equals bit 0.
- R10: While bit 0 is 1, every command strobe is rejected.
- R11: When an operation completes, bit 1 is cleared. A status write then loads `wrsr_data` through the mask 16'hE7FC, so bits 12:11 always read 0 and bits 1:0 are never taken from the data.
- R12: For each strobe, exactly one of `cmd_accept` and `cmd_reject` is 1. A rejected command leaves `status_q` unchanged. During `pwr_cycle` both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_cycle | input | 1 | One-cycle pulse marking a power-down/power-up event |
| wp_n | input | 1 | Active-low write-protect pin level |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| wrsr_data | input | 16 | Data word carried by the status write |
| cmd_pp | input | 1 | Page-program command strobe |
| cmd_se | input | 1 | Sector-erase command strobe |
| cmd_be | input | 1 | Block-erase command strobe |
| cmd_ce | input | 1 | Chip-erase command strobe |
| region_protected | input | 1 | Target address lies in the block-protected area |
| cmd_accept | output | 1 | Strobe in this cycle is accepted |
| cmd_reject | output | 1 | Strobe in this cycle is rejected |
| busy | output | 1 | Internal operation in progress |
| status_q | output | 16 | Status/control word for readback |

## Verification
The assertions assume that at most one command strobe is high in any cycle. They also assume that `pwr_cycle` is a pulse that is never held during reset. The decoder gives the lowest-numbered strobe priority, but the checks only describe the one-hot case. The bench keeps within these limits by driving every stimulus through one per-cycle task that raises a single strobe chosen by a random kind code. The random status-write data is also steered away from the permanent-lock encoding most of the time, so that the later cycles still reach the other protection modes.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int STAT_W = 16;
    localparam int B_WIP  = 0;
    localparam int B_WEL  = 1;
    localparam int B_CMP  = 14;
    localparam logic [STAT_W-1:0] WR_MASK = 16'hE7FC;

    typedef enum logic { ST_IDLE, ST_BUSY } fsm_e;

    typedef enum logic [2:0] {
        K_NONE, K_WREN, K_WRDI, K_WRSR, K_ARRAY, K_CHIP
    } cmd_kind_e;

    function automatic logic srp_permits(input logic [1:0] srp, input logic wp_n);
        logic ok;
        case (srp)
            2'b00:   ok = 1'b1;
            2'b01:   ok = wp_n;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/fsg_gate.sv
module fsg_gate
    import fsg_pkg::*;
(
    input  logic              pwr_cycle,
    input  logic              idle,
    input  logic              wp_n,
    input  logic              region_protected,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_pp,
    input  logic              cmd_se,
    input  logic              cmd_be,
    input  logic              cmd_ce,
    input  logic [STAT_W-1:0] stat,
    output cmd_kind_e         kind,
    output logic              accept,
    output logic              reject
);
    logic allowed;
    logic live;

    always_comb begin
        if (cmd_wren)                        kind = K_WREN;
        else if (cmd_wrdi)                   kind = K_WRDI;
        else if (cmd_wrsr)                   kind = K_WRSR;
        else if (cmd_pp || cmd_se || cmd_be) kind = K_ARRAY;
        else if (cmd_ce)                     kind = K_CHIP;
        else                                 kind = K_NONE;
    end

    always_comb begin
        unique case (kind)
            K_NONE:  allowed = 1'b0;
            K_WREN:  allowed = 1'b1;
            K_WRDI:  allowed = 1'b1;
            K_WRSR:  allowed = stat[B_WEL] && srp_permits(stat[8:7], wp_n);
            K_ARRAY: allowed = stat[B_WEL] && !region_protected;
            K_CHIP:  allowed = stat[B_WEL] && (stat[4:2] == 3'b000) && !stat[B_CMP];
            default: allowed = 1'b0;
        endcase
    end

    assign live   = (kind != K_NONE) && !pwr_cycle;
    assign accept = live && idle && allowed;
    assign reject = live && !accept;
endmodule

// File: rtl/fsg_timer.sv
module fsg_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clear || start) cnt_q <= '0;
        else if (run)           cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
    import fsg_pkg::*;
#(
    parameter int OP_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_cycle,
    input  logic        wp_n,
    input  logic        cmd_wren,
    input  logic        cmd_wrdi,
    input  logic        cmd_wrsr,
    input  logic [15:0] wrsr_data,
    input  logic        cmd_pp,
    input  logic        cmd_se,
    input  logic        cmd_be,
    input  logic        cmd_ce,
    input  logic        region_protected,
    output logic        cmd_accept,
    output logic        cmd_reject,
    output logic        busy,
    output logic [15:0] status_q
);
    fsm_e              state_q, state_d;
    cmd_kind_e         kind;
    logic [STAT_W-1:0] ctl_q;
    logic [STAT_W-1:0] pend_q;
    logic              pend_wr_q;
    logic              wel_q;
    logic              op_done;
    logic              go_busy;
    logic              acc;

    fsg_gate u_gate (
        .pwr_cycle        (pwr_cycle),
        .idle             (state_q == ST_IDLE),
        .wp_n             (wp_n),
        .region_protected (region_protected),
        .cmd_wren         (cmd_wren),
        .cmd_wrdi         (cmd_wrdi),
        .cmd_wrsr         (cmd_wrsr),
        .cmd_pp           (cmd_pp),
        .cmd_se           (cmd_se),
        .cmd_be           (cmd_be),
        .cmd_ce           (cmd_ce),
        .stat             (status_q),
        .kind             (kind),
        .accept           (acc),
        .reject           (cmd_reject)
    );

    assign go_busy = acc && (kind == K_WRSR || kind == K_ARRAY || kind == K_CHIP);

    fsg_timer #(.CYCLES(OP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pwr_cycle),
        .start (go_busy),
        .run   (state_q == ST_BUSY),
        .done  (op_done)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_busy) state_d = ST_BUSY;
            ST_BUSY: if (op_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (pwr_cycle) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // status word and pending data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            pend_q    <= '0;
            pend_wr_q <= 1'b0;
            wel_q     <= 1'b0;
        end else if (pwr_cycle) begin
            wel_q     <= 1'b0;
            pend_wr_q <= 1'b0;
            if (ctl_q[8:7] == 2'b10) ctl_q[8:7] <= 2'b00;
        end else if (state_q == ST_BUSY && op_done) begin
            wel_q     <= 1'b0;
            pend_wr_q <= 1'b0;
            if (pend_wr_q) ctl_q <= pend_q & WR_MASK;
        end else if (acc) begin
            case (kind)
                K_WREN: wel_q <= 1'b1;
                K_WRDI: wel_q <= 1'b0;
                K_WRSR: begin
                    pend_q    <= wrsr_data;
                    pend_wr_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q == ST_BUSY);
        cmd_accept = acc;
        status_q   = ctl_q;
        status_q[B_WEL] = wel_q;
        status_q[B_WIP] = busy;
    end
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter int OP_CYCLES = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pwr_cycle,
    input logic        wp_n,
    input logic        cmd_wren,
    input logic        cmd_wrdi,
    input logic        cmd_wrsr,
    input logic        cmd_pp,
    input logic        cmd_se,
    input logic        cmd_be,
    input logic        cmd_ce,
    input logic        cmd_accept,
    input logic        cmd_reject,
    input logic        busy,
    input logic [15:0] status_q
);
    logic any_cmd, guarded_cmd;
    int   run_cnt;

    assign any_cmd     = cmd_wren | cmd_wrdi | cmd_wrsr | cmd_pp | cmd_se | cmd_be | cmd_ce;
    assign guarded_cmd = cmd_wrsr | cmd_pp | cmd_se | cmd_be | cmd_ce;

    always_ff @(posedge clk) begin
        if (!rst_n || pwr_cycle) run_cnt <= 0;
        else if (busy)           run_cnt <= run_cnt + 1;
        else                     run_cnt <= 0;
    end

    // R12
    excl_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_reject));
    // R9
    busy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == status_q[0]);
    // R9
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !busy && !$past(pwr_cycle)) |-> (run_cnt == OP_CYCLES));
    // R3
    wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (guarded_cmd && !status_q[1]) |-> !cmd_accept);
    // R10
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && any_cmd) |-> !cmd_accept);
    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[12:11] == 2'b00);
    // R6
    otp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[8:7] == 2'b11) |=> (status_q[8:7] == 2'b11));
    // R12
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reject && !busy && !pwr_cycle) |=> $stable(status_q));
    // R8
    ce_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ce && ((status_q[4:2] != 3'b000) || status_q[14])) |-> !cmd_accept);
    // R4
    hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && status_q[8:7] == 2'b01 && !wp_n) |-> !cmd_accept);
endmodule

bind flash_status_guard fsg_checker #(.OP_CYCLES(OP_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_cycle  (pwr_cycle),
    .wp_n       (wp_n),
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .cmd_wrsr   (cmd_wrsr),
    .cmd_pp     (cmd_pp),
    .cmd_se     (cmd_se),
    .cmd_be     (cmd_be),
    .cmd_ce     (cmd_ce),
    .cmd_accept (cmd_accept),
    .cmd_reject (cmd_reject),
    .busy       (busy),
    .status_q   (status_q)
);

// File: tb/flash_status_guard_bench.sv
module flash_status_guard_bench;
    localparam int N = 5;
    localparam int KN = 0, KWREN = 1, KWRDI = 2, KWRSR = 3, KPP = 4, KSE = 5, KBE = 6, KCE = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_cycle = 0, wp_n = 1, region_protected = 0;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pp = 0, cmd_se = 0, cmd_be = 0, cmd_ce = 0;
    logic [15:0] wrsr_data = '0;
    logic cmd_accept, cmd_reject, busy;
    logic [15:0] status_q;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [15:0] m_ctl, m_pend;
    logic m_wel, m_pw;
    int   m_left;

    always #5 clk = ~clk;

    flash_status_guard #(.OP_CYCLES(N)) u_flash_status_guard (
        .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data),
        .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be), .cmd_ce(cmd_ce),
        .region_protected(region_protected), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
        .busy(busy), .status_q(status_q)
    );

    function automatic logic [15:0] exp_status();
        return (m_ctl & 16'hFFFC) | {14'b0, m_wel, (m_left > 0)};
    endfunction

    function automatic logic exp_accept(int k, logic rp, logic wp, logic pw);
        logic ok;
        if (pw || k == KN || m_left > 0) return 1'b0;
        case (k)
            KWREN, KWRDI: ok = 1'b1;
            KWRSR: ok = m_wel && (m_ctl[8:7] == 2'b00 || (m_ctl[8:7] == 2'b01 && wp));
            KPP, KSE, KBE: ok = m_wel && !rp;
            KCE: ok = m_wel && m_ctl[4:2] == 3'b000 && !m_ctl[14];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(int k, logic [15:0] d, logic rp, logic wp, logic pw, string tag);
        logic ea;
        @(negedge clk);
        cmd_wren = (k == KWREN); cmd_wrdi = (k == KWRDI); cmd_wrsr = (k == KWRSR);
        cmd_pp = (k == KPP); cmd_se = (k == KSE); cmd_be = (k == KBE); cmd_ce = (k == KCE);
        wrsr_data = d; region_protected = rp; wp_n = wp; pwr_cycle = pw;
        #1;
        ea = exp_accept(k, rp, wp, pw);
        check({tag, " status"}, status_q, exp_status());
        check({tag, " busy"}, {15'b0, busy}, {15'b0, (m_left > 0)});
        if (k != KN) begin
            check({tag, " accept"}, {15'b0, cmd_accept}, {15'b0, ea});
            check({tag, " reject"}, {15'b0, cmd_reject}, {15'b0, !ea && !pw});
        end
        @(posedge clk);
        if (pw) begin
            m_left = 0; m_wel = 0; m_pw = 0;
            if (m_ctl[8:7] == 2'b10) m_ctl[8:7] = 2'b00;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                m_wel = 0;
                if (m_pw) m_ctl = m_pend & 16'hE7FC;
                m_pw = 0;
            end
        end else if (ea) begin
            case (k)
                KWREN: m_wel = 1;
                KWRDI: m_wel = 0;
                KWRSR: begin m_pend = d; m_pw = 1; m_left = N; end
                default: begin m_pw = 0; m_left = N; end
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; pwr_cycle = 0;
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_pp = 0; cmd_se = 0; cmd_be = 0; cmd_ce = 0;
        repeat (2) @(posedge clk);
        m_ctl = 0; m_pend = 0; m_wel = 0; m_pw = 0; m_left = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(KN, 16'h0, 0, 1, 0, tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        cyc(KN, 0, 0, 1, 0, "R1");
        cyc(KWRSR, 16'h0004, 0, 1, 0, "R3");
        cyc(KPP, 0, 0, 1, 0, "R3");
        cyc(KCE, 0, 0, 1, 0, "R3");
        cyc(KWREN, 0, 0, 1, 0, "R2");
        cyc(KN, 0, 0, 1, 0, "R2");
        cyc(KWRDI, 0, 0, 1, 0, "R2");
        cyc(KN, 0, 0, 1, 0, "R2");
        // masked status write, busy window, rejections while busy
        cyc(KWREN, 0, 0, 1, 0, "R11");
        cyc(KWRSR, 16'h1E7F, 0, 1, 0, "R11");
        cyc(KWREN, 0, 0, 1, 0, "R10");
        cyc(KCE, 0, 0, 1, 0, "R10");
        idle(N, "R9");
        cyc(KN, 0, 0, 1, 0, "R11");
        // chip erase gating
        cyc(KWREN, 0, 0, 1, 0, "R8");
        cyc(KCE, 0, 0, 1, 0, "R8");
        cyc(KWRSR, 16'h0000, 0, 1, 0, "R12");
        idle(N + 1, "R9");
        cyc(KWREN, 0, 0, 1, 0, "R8");
        cyc(KCE, 0, 0, 1, 0, "R8");
        idle(N + 1, "R9");
        cyc(KWREN, 0, 0, 1, 0, "R8");
        cyc(KWRSR, 16'h4000, 0, 1, 0, "R8");
        idle(N + 1, "R9");
        cyc(KWREN, 0, 0, 1, 0, "R8");
        cyc(KCE, 0, 0, 1, 0, "R8");
        // region protection
        cyc(KPP, 0, 1, 1, 0, "R7");
        cyc(KBE, 0, 1, 1, 0, "R7");
        cyc(KSE, 0, 0, 1, 0, "R7");
        idle(N + 1, "R9");
        // pin-dependent mode
        cyc(KWREN, 0, 0, 1, 0, "R4");
        cyc(KWRSR, 16'h0080, 0, 1, 0, "R4");
        idle(N + 1, "R4");
        cyc(KWREN, 0, 0, 1, 0, "R4");
        cyc(KWRSR, 16'h0084, 0, 0, 0, "R4");
        cyc(KWRSR, 16'h0000, 0, 1, 0, "R4");
        idle(N + 1, "R4");
        cyc(KWREN, 0, 0, 0, 0, "R4");
        cyc(KWRSR, 16'h0100, 0, 0, 0, "R4");
        idle(N + 1, "R5");
        // lock until power cycle
        cyc(KWREN, 0, 0, 1, 0, "R5");
        cyc(KWRSR, 16'h0000, 0, 1, 0, "R5");
        cyc(KN, 0, 0, 1, 1, "R5");
        cyc(KN, 0, 0, 1, 0, "R5");
        cyc(KWREN, 0, 0, 1, 0, "R5");
        cyc(KSE, 0, 0, 1, 0, "R5");
        cyc(KN, 0, 0, 1, 1, "R5");
        cyc(KN, 0, 0, 1, 0, "R5");
        // permanent lock
        cyc(KWREN, 0, 0, 1, 0, "R6");
        cyc(KWRSR, 16'h0180, 0, 1, 0, "R6");
        idle(N + 1, "R6");
        cyc(KN, 0, 0, 1, 1, "R6");
        cyc(KWREN, 0, 0, 1, 0, "R6");
        cyc(KWRSR, 16'h0000, 0, 1, 0, "R6");
        cyc(KN, 0, 0, 1, 0, "R6");
        // constrained random
        for (int blk = 0; blk < 8; blk++) begin
            do_reset();
            cyc(KN, 0, 0, 1, 0, "R1");
            for (int i = 0; i < 400; i++) begin
                int k;
                logic [15:0] d;
                k = $urandom_range(0, 7);
                d = 16'($urandom);
                if (d[8:7] == 2'b11 && $urandom_range(0, 7) != 0) d[8] = 1'b0;
                cyc(k, d, 1'($urandom), 1'($urandom), ($urandom_range(0, 63) == 0), "R12 random");
            end
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule